// File: doc/BRIEF.md
# Single-Precision Sign Injection and Boxed Register Writeback

This block is the writeback stage for single-precision results going into a floating-point register file. Each register in that file is FLEN bits wide, and FLEN may be 32 or 64. On each write the block chooses one of two 32-bit sources. The first is a value supplied from outside, such as an arithmetic unit result or an integer-to-float move. The second is one of three sign-injection results, computed from the low 32 bits of two source registers in the same file.

When FLEN is 64, every 32-bit value is widened before it is stored. The low half holds the value and the high half is forced to all ones. This marks the register as holding a boxed single-precision number. When FLEN is 32, the value is stored unchanged.

The write also appears on a registered output one cycle later. A separate combinational read port lets any register be inspected. This block does no rounding and produces no exception flags. Sign injection and moves leave any flag state untouched.

Top module: `fpbw_top`

## Requirements
- R1: With FLEN = 32, the stored and reported value equals the 32-bit selected value bit for bit.
- R2: With FLEN = 64, bits 63..32 of every stored and reported value are all ones and bits 31..0 hold the 32-bit selected value.
- R3: Operation code 1 (copy sign) yields bits 30..0 of operand A with bit 31 taken from bit 31 of operand B.
- R4: Operation code 2 (negated sign) yields bits 30..0 of operand A with bit 31 equal to the inverse of bit 31 of operand B.
- R5: Operation code 3 (xor sign) yields operand A with bit 31 replaced by A[31] xor B[31].
- R6: Operand A and operand B are bits 31..0 of the registers addressed by `src_a_addr` and `src_b_addr`, read in the cycle of the write. A source equal to the destination supplies the old contents.
- R7: Operation code 0 (pass) selects `ext_result`, covering both arithmetic results and integer-to-float moves, through the same widening path as R1/R2.
- R8: A register changes only on a rising clock edge with `wr_en` high. `wb_valid` is high in exactly the cycle after such an edge.
- R9: A clock edge with `rst` high clears `wb_valid` and `wb_value` to zero.
- R10: In the cycle after a write, `wb_value` holds the stored value, and `rd_data` for that address shows the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write the selected value this edge |
| wr_op | input | 2 | 0 pass, 1 copy sign, 2 negated sign, 3 xor sign |
| wr_addr | input | AW | Destination register |
| src_a_addr | input | AW | Operand A register |
| src_b_addr | input | AW | Operand B register |
| ext_result | input | 32 | External single-precision value |
| rd_addr | input | AW | Inspection read address |
| rd_data | output | FLEN | Contents of register `rd_addr` |
| wb_value | output | FLEN | Value written on the previous edge |
| wb_valid | output | 1 | A write happened on the previous edge |

## Verification
A fault in the operand read or in the sign logic shows up in the cycle after the write, as a wrong bit 31 or a wrong magnitude in `wb_value`. The same fault then persists in `rd_data` for that register until it is overwritten. A fault in the widening stage shows up in the same cycle as a high half that is not all ones. On the 32-bit build it shows up as a changed value. Each stored result later becomes an operand, so a corrupted register also spreads into the sign-injection results that read it. The bench follows that propagation against its own register model.

// File: rtl/fpbw_pkg.sv
package fpbw_pkg;
  typedef enum logic [1:0] {
    OP_PASS  = 2'd0,
    OP_SGNJ  = 2'd1,
    OP_SGNJN = 2'd2,
    OP_SGNJX = 2'd3
  } fpbw_op_e;

  localparam int unsigned SP_W    = 32;
  localparam int unsigned SIGN_IX = SP_W - 1;
endpackage

// File: rtl/fpbw_regfile.sv
module fpbw_regfile #(
  parameter int unsigned W     = 64,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [W-1:0]  ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [W-1:0]  rb_data,
  input  logic [AW-1:0] rc_addr,
  output logic [W-1:0]  rc_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];
  assign rc_data = mem[rc_addr];
endmodule

// File: rtl/fpbw_sgnj.sv
module fpbw_sgnj
  import fpbw_pkg::*;
(
  input  fpbw_op_e          op,
  input  logic [SP_W-1:0]   ext,
  input  logic [SP_W-1:0]   opa,
  input  logic [SP_W-1:0]   opb,
  output logic [SP_W-1:0]   res
);
  logic [SIGN_IX-1:0] mag;
  logic               sa, sb;

  assign mag = opa[SIGN_IX-1:0];
  assign sa  = opa[SIGN_IX];
  assign sb  = opb[SIGN_IX];

  always_comb begin
    unique case (op)
      OP_SGNJ:  res = {sb, mag};
      OP_SGNJN: res = {~sb, mag};
      OP_SGNJX: res = {sa ^ sb, mag};
      default:  res = ext;
    endcase
  end
endmodule

// File: rtl/fpbw_boxer.sv
module fpbw_boxer
  import fpbw_pkg::*;
#(
  parameter int unsigned FLEN = 64
) (
  input  logic [SP_W-1:0] sp_in,
  output logic [FLEN-1:0] boxed
);
  generate
    if (FLEN == SP_W) begin : g_narrow
      assign boxed = sp_in;
    end else begin : g_wide
      localparam int unsigned PAD = FLEN - SP_W;
      assign boxed = {{PAD{1'b1}}, sp_in};
    end
  endgenerate
endmodule

// File: rtl/fpbw_top.sv
module fpbw_top
  import fpbw_pkg::*;
#(
  parameter int unsigned FLEN  = 64,
  parameter int unsigned NREGS = 32,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [1:0]      wr_op,
  input  logic [AW-1:0]   wr_addr,
  input  logic [AW-1:0]   src_a_addr,
  input  logic [AW-1:0]   src_b_addr,
  input  logic [31:0]     ext_result,
  input  logic [AW-1:0]   rd_addr,
  output logic [FLEN-1:0] rd_data,
  output logic [FLEN-1:0] wb_value,
  output logic            wb_valid
);
  logic [FLEN-1:0] ra_full, rb_full, boxed;
  logic [SP_W-1:0] op_a, op_b, sel_val;
  fpbw_op_e        op_sel;

  assign op_sel = fpbw_op_e'(wr_op);
  assign op_a   = ra_full[SP_W-1:0];
  assign op_b   = rb_full[SP_W-1:0];

  fpbw_regfile #(.W(FLEN), .DEPTH(NREGS)) u_rf (
    .clk     (clk),
    .we      (wr_en),
    .waddr   (wr_addr),
    .wdata   (boxed),
    .ra_addr (src_a_addr),
    .ra_data (ra_full),
    .rb_addr (src_b_addr),
    .rb_data (rb_full),
    .rc_addr (rd_addr),
    .rc_data (rd_data)
  );

  fpbw_sgnj u_sgnj (
    .op  (op_sel),
    .ext (ext_result),
    .opa (op_a),
    .opb (op_b),
    .res (sel_val)
  );

  fpbw_boxer #(.FLEN(FLEN)) u_box (
    .sp_in (sel_val),
    .boxed (boxed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0;
      wb_value <= '0;
    end else begin
      wb_valid <= wr_en;
      if (wr_en) wb_value <= boxed;
    end
  end
endmodule

// File: rtl/fpbw_chk.sv
module fpbw_chk #(
  parameter int unsigned FLEN = 64,
  parameter int unsigned AW   = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic [1:0]      wr_op,
  input logic [AW-1:0]   wr_addr,
  input logic [31:0]     ext_result,
  input logic [31:0]     opa,
  input logic [31:0]     opb,
  input logic [AW-1:0]   rd_addr,
  input logic [FLEN-1:0] rd_data,
  input logic [FLEN-1:0] wb_value,
  input logic            wb_valid
);
  p_valid_after_write_r8: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> wb_valid);
  p_no_valid_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> !wb_valid);
  p_reset_clears_r9: assert property (@(posedge clk)
    rst |=> (!wb_valid && wb_value == '0));
  p_pass_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_op == 2'd0) |=> wb_value[31:0] == $past(ext_result));
  p_copy_sign_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_op == 2'd1) |=> wb_value[31:0] == {$past(opb[31]), $past(opa[30:0])});
  p_neg_sign_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_op == 2'd2) |=> wb_value[31:0] == {~$past(opb[31]), $past(opa[30:0])});
  p_xor_sign_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_op == 2'd3) |=> wb_value[31:0] == ($past(opa) ^ {$past(opb[31]), 31'd0}));
  p_readback_r10: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && rd_addr == $past(wr_addr)) |-> rd_data == wb_value);

  generate
    if (FLEN > 32) begin : g_wide
      p_box_upper_r2: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (&wb_value[FLEN-1:32]));
    end
  endgenerate
endmodule

bind fpbw_top fpbw_chk #(.FLEN(FLEN), .AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .wr_op      (wr_op),
  .wr_addr    (wr_addr),
  .ext_result (ext_result),
  .opa        (op_a),
  .opb        (op_b),
  .rd_addr    (rd_addr),
  .rd_data    (rd_data),
  .wb_value   (wb_value),
  .wb_valid   (wb_valid)
);

// File: tb/fpbw_top_test.sv
module fpbw_top_test;
  localparam int unsigned NREGS = 32;
  localparam int unsigned AW    = $clog2(NREGS);
  localparam int unsigned NVEC  = 13;
  localparam int unsigned VW    = 2 + 3*AW + 32;

  // entry: {op, dst, src_a, src_b, ext}
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {2'd0, 5'd1,  5'd0, 5'd0, 32'h3F800000},
    {2'd0, 5'd2,  5'd0, 5'd0, 32'hC0000000},
    {2'd0, 5'd3,  5'd0, 5'd0, 32'h7FC00000},
    {2'd0, 5'd4,  5'd0, 5'd0, 32'h80000000},
    {2'd1, 5'd5,  5'd1, 5'd2, 32'hDEADBEEF},
    {2'd2, 5'd6,  5'd1, 5'd2, 32'h0},
    {2'd3, 5'd7,  5'd2, 5'd2, 32'h0},
    {2'd3, 5'd8,  5'd2, 5'd1, 32'h0},
    {2'd2, 5'd9,  5'd3, 5'd3, 32'h0},
    {2'd1, 5'd10, 5'd4, 5'd1, 32'h0},
    {2'd1, 5'd1,  5'd1, 5'd1, 32'h0},
    {2'd2, 5'd2,  5'd2, 5'd2, 32'h0},
    {2'd0, 5'd31, 5'd0, 5'd0, 32'h12345678}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_op = '0;
  logic [AW-1:0] wr_addr = '0, src_a_addr = '0, src_b_addr = '0, rd_addr = '0;
  logic [31:0] ext_result = '0;
  logic [63:0] rd64, wb64;
  logic [31:0] rd32, wb32;
  logic v64, v32;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] model [NREGS];

  always #4 clk = ~clk;

  fpbw_top #(.FLEN(64), .NREGS(NREGS)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_op(wr_op), .wr_addr(wr_addr),
    .src_a_addr(src_a_addr), .src_b_addr(src_b_addr), .ext_result(ext_result),
    .rd_addr(rd_addr), .rd_data(rd64), .wb_value(wb64), .wb_valid(v64));

  fpbw_top #(.FLEN(32), .NREGS(NREGS)) uut_n (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_op(wr_op), .wr_addr(wr_addr),
    .src_a_addr(src_a_addr), .src_b_addr(src_b_addr), .ext_result(ext_result),
    .rd_addr(rd_addr), .rd_data(rd32), .wb_value(wb32), .wb_valid(v32));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_val(input logic [1:0] op, input logic [31:0] a,
                                          input logic [31:0] b, input logic [31:0] e);
    case (op)
      2'd1:    return {b[31], a[30:0]};
      2'd2:    return {~b[31], a[30:0]};
      2'd3:    return {a[31] ^ b[31], a[30:0]};
      default: return e;
    endcase
  endfunction

  function automatic string op_tag(input logic [1:0] op);
    case (op)
      2'd1:    return "R3 copy-sign (R6 operands)";
      2'd2:    return "R4 negated-sign (R6 operands)";
      2'd3:    return "R5 xor-sign (R6 operands)";
      default: return "R7 pass";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 wb_valid after reset (64)", {63'd0, v64}, 64'd0);
    chk("R9 wb_value after reset (64)", wb64, 64'd0);
    chk("R9 wb_value after reset (32)", {32'd0, wb32}, 64'd0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] op;
      logic [AW-1:0] d, sa, sb;
      logic [31:0] e, exp;
      {op, d, sa, sb, e} = VEC[i];
      exp = ref_val(op, model[sa], model[sb], e);
      wr_en = 1'b1; wr_op = op; wr_addr = d; src_a_addr = sa; src_b_addr = sb;
      ext_result = e; rd_addr = d;
      @(negedge clk);
      wr_en = 1'b0;
      model[d] = exp;
      chk({op_tag(op), " R2 boxed wb (64)"}, wb64, {32'hFFFFFFFF, exp});
      chk({op_tag(op), " R1 plain wb (32)"}, {32'd0, wb32}, {32'd0, exp});
      chk("R10 readback equals wb (64)", rd64, wb64);
      chk("R10 readback (32)", {32'd0, rd32}, {32'd0, exp});
      chk("R8 wb_valid after write", {62'd0, v64, v32}, 64'd3);
    end

    // R8: no write when wr_en is low
    wr_op = 2'd0; wr_addr = 5'd5; ext_result = 32'h00000001; rd_addr = 5'd5;
    @(negedge clk);
    chk("R8 idle keeps register (64)", rd64, {32'hFFFFFFFF, model[5]});
    chk("R8 idle keeps register (32)", {32'd0, rd32}, {32'd0, model[5]});
    chk("R8 wb_valid low when idle", {62'd0, v64, v32}, 64'd0);

    // R9: reset mid-run clears the registered output
    rst = 1'b1;
    @(negedge clk);
    chk("R9 wb_value cleared by reset", wb64, 64'd0);
    chk("R9 wb_valid cleared by reset", {63'd0, v64}, 64'd0);
    rst = 1'b0;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule